// File: doc/BRIEF.md
# Whole-Message Receive Port Buffer

This block sits at the receive side of a message port. A writer delivers each message as a start beat that declares the length, then one byte per data beat, then an end beat. Bytes go into a staging slot. The message is committed only on the end beat, and only when the number of bytes received equals the declared length. Until then the reader sees nothing new. A message that is aborted, restarted, too long or of the wrong length is thrown away, and whatever is already stored stays as it is.

The port behaves in one of two ways, chosen by a static configuration pin that is captured while reset is held.

- **Sampling behaviour:** the port keeps only the newest committed message. Reading does not consume it, and a fresh flag marks data that has not been acknowledged yet.
- **Queueing behaviour:** the port keeps up to `SLOTS` messages in arrival order, and each acknowledge pops the oldest one. A commit that finds the queue full is dropped and raises a sticky overflow flag.

The reader sees the valid flag, the length and the bytes of the current (oldest or newest) message. It picks a byte with an address input, and the byte is returned combinationally.

Top module: `msg_port_buffer`

## Requirements
- R1: The behaviour select `queue_mode_i` (1 = queueing, 0 = sampling) is captured on every clock edge while `rst_n` is low; changes after reset is released have no effect.
- R2: A message becomes readable only after the edge that samples its end beat, and only if the byte count equals the declared `wr_len_i` and lies in 1..MAX_BYTES (MAX_BYTES up to 64 accepted); before that the read outputs, fresh and overflow are unchanged.
- R3: A message that is cut by `wr_abort_i`, superseded by a new start beat, shorter or longer than declared, longer than MAX_BYTES, or of declared length 0 is discarded, and the stored contents and flags are unchanged.
- R4: In sampling behaviour each committed message replaces the stored one; `rd_done_i` does not remove it, so repeated reads return the same bytes.
- R5: `fresh_o` is set by a commit in sampling behaviour and cleared by `rd_done_i`; when both fall in the same cycle it ends set; in queueing behaviour it stays 0.
- R6: In queueing behaviour committed messages are read in arrival order, and `rd_done_i` with a message present removes the oldest one; `rd_msg_valid_o` is 1 while at least one message is stored.
- R7: In queueing behaviour a commit that finds SLOTS messages stored, with no pop in the same cycle, is dropped, leaves the queue unchanged and sets `overflow_o`; a pop in the same cycle lets the commit in.
- R8: `overflow_o` stays set until `clr_ovf_i`; an overflow in the same cycle as `clr_ovf_i` leaves it set.
- R9: After reset `rd_msg_valid_o`, `fresh_o` and `overflow_o` are 0.
- R10: `rd_len_o` gives the byte count of the message being read, and `rd_data_o` gives its byte at offset `rd_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| queue_mode_i | input | 1 | Behaviour select captured during reset: 1 queueing, 0 sampling |
| wr_start_i | input | 1 | Start beat of a message; carries the declared length |
| wr_len_i | input | LW | Declared byte count, read on the start beat |
| wr_valid_i | input | 1 | Data beat strobe, one byte per beat |
| wr_data_i | input | 8 | Data byte |
| wr_end_i | input | 1 | End beat, carries no byte; commits if the message is well formed |
| wr_abort_i | input | 1 | Discards the message in progress |
| rd_addr_i | input | AW | Byte offset inside the message being read |
| rd_done_i | input | 1 | Acknowledge: pops in queueing behaviour, clears fresh in sampling behaviour |
| clr_ovf_i | input | 1 | Clears the overflow flag |
| rd_msg_valid_o | output | 1 | A message is readable |
| rd_len_o | output | LW | Length of the message being read |
| rd_data_o | output | 8 | Byte at `rd_addr_i` |
| fresh_o | output | 1 | Unread newest message (sampling behaviour) |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
Three pairs of events can fall in the same cycle: an end beat and a reader acknowledge, an end beat that overflows and an overflow clear, and a commit and a pop on a full queue. The bench provokes each pair with directed cases. It then keeps provoking them at random by raising `rd_done_i` and `clr_ovf_i` on the end beat of random messages. Each outcome is judged against a bench model that applies the pop first, then the commit, with set taking priority over clear, and that then compares the flags, the length and every byte of the head message.

// File: rtl/msg_port_buffer.sv
module msg_port_buffer #(
  parameter int SLOTS     = 4,
  parameter int MAX_BYTES = 64,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          queue_mode_i,
  input  logic          wr_start_i,
  input  logic [LW-1:0] wr_len_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_end_i,
  input  logic          wr_abort_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_done_i,
  input  logic          clr_ovf_i,
  output logic          rd_msg_valid_o,
  output logic [LW-1:0] rd_len_o,
  output logic [7:0]    rd_data_o,
  output logic          fresh_o,
  output logic          overflow_o
);
  localparam int NS = SLOTS + 1;
  localparam int SW = $clog2(NS);
  localparam int CW = $clog2(SLOTS + 1);

  logic          mode_q;
  logic [7:0]    mem   [NS][MAX_BYTES];
  logic [LW-1:0] len_q [NS];
  logic [SW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic          have_q, fresh_q, ovf_q;
  logic          in_msg_q, bad_q;
  logic [LW-1:0] cnt_q, exp_q;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(NS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic take_byte, done, good, full, pop, push, drop, swap;

  assign take_byte = in_msg_q && wr_valid_i && !wr_start_i && !wr_abort_i && !wr_end_i
                     && (cnt_q != LW'(MAX_BYTES));
  assign done  = in_msg_q && wr_end_i && !wr_start_i && !wr_abort_i;
  assign good  = done && !bad_q && (cnt_q == exp_q) && (exp_q != '0);
  assign full  = (count_q == CW'(SLOTS));
  assign pop   = mode_q && rd_done_i && (count_q != '0);
  assign push  = good && mode_q && (!full || pop);
  assign drop  = good && mode_q && full && !pop;
  assign swap  = good && !mode_q;

  assign rd_msg_valid_o = mode_q ? (count_q != '0) : have_q;
  assign rd_len_o       = len_q[head_q];
  assign rd_data_o      = mem[head_q][rd_addr_i];
  assign fresh_o        = fresh_q;
  assign overflow_o     = ovf_q;

  always_ff @(posedge clk) begin
    if (take_byte) mem[tail_q][cnt_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_msg_q <= 1'b0;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
      exp_q    <= '0;
    end else if (wr_start_i) begin
      in_msg_q <= 1'b1;
      bad_q    <= 1'b0;
      cnt_q    <= '0;
      exp_q    <= wr_len_i;
    end else if (wr_abort_i || done) begin
      in_msg_q <= 1'b0;
    end else if (in_msg_q && wr_valid_i) begin
      if (cnt_q == LW'(MAX_BYTES)) bad_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= queue_mode_i;
      head_q  <= '0;
      tail_q  <= queue_mode_i ? SW'(0) : SW'(1);
      count_q <= '0;
      have_q  <= 1'b0;
      fresh_q <= 1'b0;
      ovf_q   <= 1'b0;
      for (int i = 0; i < NS; i++) len_q[i] <= '0;
    end else begin
      if (push || swap) len_q[tail_q] <= cnt_q;
      if (mode_q) begin
        if (pop)  head_q <= nxt(head_q);
        if (push) tail_q <= nxt(tail_q);
        count_q <= count_q + CW'(push) - CW'(pop);
      end else if (swap) begin
        head_q <= tail_q;
        tail_q <= head_q;
        have_q <= 1'b1;
      end
      if (swap)                      fresh_q <= 1'b1;
      else if (rd_done_i && !mode_q) fresh_q <= 1'b0;
      if (drop)           ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
    end
  end
endmodule

module msg_port_buffer_chk #(
  parameter int SLOTS = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_q,
  input logic [CW-1:0] count_q,
  input logic          wr_end_i,
  input logic          rd_done_i,
  input logic          clr_ovf_i,
  input logic          rd_msg_valid_o,
  input logic          fresh_o,
  input logic          overflow_o
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $stable(mode_q)); // R1
  AST_HIDDEN_UNTIL_END: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msg_valid_o && !wr_end_i |=> !rd_msg_valid_o); // R2
  AST_SAMPLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && rd_msg_valid_o |=> rd_msg_valid_o); // R4
  AST_FRESH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && rd_done_i && !wr_end_i |=> !fresh_o); // R5
  AST_FRESH_QUEUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !fresh_o); // R5
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_msg_valid_o && !rd_done_i |=> rd_msg_valid_o); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(SLOTS)); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(wr_end_i) && mode_q); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o && !clr_ovf_i |=> overflow_o); // R8
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf_i && !wr_end_i |=> !overflow_o); // R8
endmodule

bind msg_port_buffer msg_port_buffer_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .count_q(count_q),
  .wr_end_i(wr_end_i), .rd_done_i(rd_done_i), .clr_ovf_i(clr_ovf_i),
  .rd_msg_valid_o(rd_msg_valid_o), .fresh_o(fresh_o), .overflow_o(overflow_o)
);

// File: tb/msg_port_buffer_bench.sv
module msg_port_buffer_bench;
  localparam int SLOTS = 4;
  localparam int MAXB  = 64;
  localparam int LW    = 7;
  localparam int AW    = 6;

  logic clk = 1'b0, rst_n = 1'b0, queue_mode_i = 1'b0;
  logic wr_start_i = 0, wr_valid_i = 0, wr_end_i = 0, wr_abort_i = 0;
  logic rd_done_i = 0, clr_ovf_i = 0;
  logic [LW-1:0] wr_len_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic rd_msg_valid_o, fresh_o, overflow_o;
  logic [LW-1:0] rd_len_o;
  logic [7:0] rd_data_o;

  always #10 clk = ~clk;

  msg_port_buffer #(.SLOTS(SLOTS), .MAX_BYTES(MAXB)) u_msg_port_buffer (.*);

  int vecs = 0, errs = 0;
  logic [7:0] pay [MAXB];
  logic [7:0] qm [SLOTS][MAXB];
  int qlen [SLOTS];
  int qh, qc, mode;
  logic [7:0] sm [MAXB];
  int slen;
  bit shave, sfresh, ovf_m;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit well_formed(input int n, input int decl, input int how);
    return how == 0 && n == decl && decl >= 1 && decl <= MAXB;
  endfunction

  task automatic fill_pay();
    for (int i = 0; i < MAXB; i++) pay[i] = 8'($urandom);
  endtask

  task automatic do_reset(input bit qmode);
    rst_n = 0; queue_mode_i = qmode;
    repeat (3) @(negedge clk);
    rst_n = 1;
    queue_mode_i = ~qmode;
    mode = qmode; qh = 0; qc = 0; shave = 0; sfresh = 0; ovf_m = 0; slen = 0;
  endtask

  task automatic check_all(input string req);
    bit v;
    int l;
    bit bytes_ok;
    int ba, be;
    v = mode ? (qc != 0) : shave;
    l = mode ? qlen[qh] : slen;
    @(negedge clk);
    chk(rd_msg_valid_o == v, {req, " valid"}, rd_msg_valid_o, v);
    chk(fresh_o == (mode ? 1'b0 : sfresh), {req, " fresh"}, fresh_o, mode ? 0 : sfresh);
    chk(overflow_o == ovf_m, {req, " overflow"}, overflow_o, ovf_m);
    if (v) begin
      chk(rd_len_o == LW'(l), {req, " R10 length"}, rd_len_o, l);
      bytes_ok = 1; ba = 0; be = 0;
      for (int i = 0; i < l; i++) begin
        @(negedge clk);
        rd_addr_i = AW'(i);
        #3;
        if (bytes_ok && rd_data_o !== (mode ? qm[qh][i] : sm[i])) begin
          bytes_ok = 0; ba = rd_data_o; be = mode ? qm[qh][i] : sm[i];
        end
      end
      chk(bytes_ok, {req, " R10 data"}, ba, be);
    end
  endtask

  task automatic model_end(input int n, input int decl, input int how, input bit rd, input bit clr);
    bit g, popped, dropped;
    int t;
    g = well_formed(n, decl, how);
    dropped = 0;
    if (!mode) begin
      if (rd) sfresh = 0;
      if (g) begin
        for (int i = 0; i < n; i++) sm[i] = pay[i];
        slen = n; shave = 1; sfresh = 1;
      end
    end else begin
      popped = rd && qc > 0;
      if (g && qc == SLOTS && !popped) dropped = 1;
      if (popped) begin qh = (qh + 1) % SLOTS; qc--; end
      if (g && !dropped) begin
        t = (qh + qc) % SLOTS;
        for (int i = 0; i < n; i++) qm[t][i] = pay[i];
        qlen[t] = n; qc++;
      end
    end
    if (dropped) ovf_m = 1;
    else if (clr) ovf_m = 0;
  endtask

  // how: 0 end beat, 1 abort, 2 left open (next start supersedes it)
  task automatic send(input int n, input int decl, input int how, input bit rd, input bit clr,
                      input bit peek, input string req);
    @(negedge clk);
    wr_start_i = 1; wr_len_i = LW'(decl);
    @(negedge clk);
    wr_start_i = 0;
    for (int i = 0; i < n; i++) begin
      wr_valid_i = 1; wr_data_i = pay[i % MAXB];
      @(negedge clk);
    end
    wr_valid_i = 0;
    if (peek) check_all({req, " R2 before end"});
    if (how == 0) begin
      wr_end_i = 1; rd_done_i = rd; clr_ovf_i = clr;
      @(negedge clk);
      wr_end_i = 0; rd_done_i = 0; clr_ovf_i = 0;
    end else if (how == 1) begin
      wr_abort_i = 1; rd_done_i = rd; clr_ovf_i = clr;
      @(negedge clk);
      wr_abort_i = 0; rd_done_i = 0; clr_ovf_i = 0;
    end
    if (how == 0) model_end(n, decl, how, rd, clr);
    else begin
      if (rd) begin
        if (!mode) sfresh = 0;
        else if (qc > 0) begin qh = (qh + 1) % SLOTS; qc--; end
      end
      if (clr) ovf_m = 0;
    end
  endtask

  task automatic ack();
    @(negedge clk); rd_done_i = 1;
    @(negedge clk); rd_done_i = 0;
    if (!mode) sfresh = 0;
    else if (qc > 0) begin qh = (qh + 1) % SLOTS; qc--; end
  endtask

  task automatic clear_ovf();
    @(negedge clk); clr_ovf_i = 1;
    @(negedge clk); clr_ovf_i = 0;
    ovf_m = 0;
  endtask

  function automatic int rnd_len();
    return 1 + int'($urandom % MAXB);
  endfunction

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n, d, h;
    void'($urandom(32'h5EED_0A1F));
    // Sampling behaviour; the select pin is flipped after reset (R1)
    do_reset(0);
    @(negedge clk);
    chk(!rd_msg_valid_o && !fresh_o && !overflow_o, "R9 reset state sampling",
        {rd_msg_valid_o, fresh_o, overflow_o}, 0);
    fill_pay(); send(10, 10, 0, 0, 0, 1, "R2"); check_all("R4 first");
    fill_pay(); send(5, 5, 0, 0, 0, 0, ""); check_all("R1 R4 replaced");
    ack(); check_all("R5 cleared, R4 still readable");
    ack(); check_all("R4 repeated read");
    fill_pay(); send(7, 7, 1, 0, 0, 0, ""); check_all("R3 abort");
    fill_pay(); send(6, 8, 0, 0, 0, 0, ""); check_all("R3 short");
    fill_pay(); send(9, 8, 0, 0, 0, 0, ""); check_all("R3 long");
    fill_pay(); send(70, 64, 0, 0, 0, 0, ""); check_all("R3 over max");
    send(0, 0, 0, 0, 0, 0, ""); check_all("R3 zero length");
    fill_pay(); send(4, 4, 2, 0, 0, 0, "");
    fill_pay(); send(12, 12, 0, 0, 0, 0, ""); check_all("R3 restart");
    fill_pay(); send(MAXB, MAXB, 0, 0, 0, 1, "R2"); check_all("R2 max length");
    fill_pay(); send(3, 3, 0, 1, 0, 0, ""); check_all("R5 commit with ack");
    for (int k = 0; k < 30; k++) begin
      fill_pay(); n = rnd_len(); h = ($urandom % 5 == 0) ? 1 : 0;
      d = ($urandom % 4 == 0) ? rnd_len() : n;
      send(n, d, h, 1'($urandom), 0, 0, "");
      check_all("R4 R5 random");
      if ($urandom % 3 == 0) begin ack(); check_all("R5 random ack"); end
    end

    // Queueing behaviour
    do_reset(1);
    @(negedge clk);
    chk(!rd_msg_valid_o && !fresh_o && !overflow_o, "R9 reset state queueing",
        {rd_msg_valid_o, fresh_o, overflow_o}, 0);
    for (int k = 0; k < 3; k++) begin fill_pay(); send(rnd_len(), 0, 2, 0, 0, 0, ""); end
    for (int k = 0; k < 3; k++) begin
      fill_pay(); n = rnd_len(); send(n, n, 0, 0, 0, k == 0, "R2");
    end
    check_all("R1 R6 head");
    for (int k = 0; k < 3; k++) begin ack(); check_all("R6 order"); end
    for (int k = 0; k < SLOTS; k++) begin fill_pay(); n = rnd_len(); send(n, n, 0, 0, 0, 0, ""); end
    fill_pay(); send(8, 8, 0, 0, 0, 0, ""); check_all("R7 overflow drop");
    fill_pay(); send(9, 9, 0, 0, 0, 0, ""); check_all("R8 sticky");
    clear_ovf(); check_all("R8 clear");
    fill_pay(); send(11, 11, 0, 1, 0, 0, ""); check_all("R7 pop with commit at full");
    fill_pay(); send(13, 13, 0, 0, 1, 0, ""); check_all("R8 overflow with clear");
    for (int k = 0; k < SLOTS; k++) begin ack(); check_all("R7 R6 contents kept"); end
    ack(); check_all("R6 pop on empty");
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 3 == 0) begin
        ack(); check_all("R6 random pop");
      end else begin
        fill_pay(); n = rnd_len(); h = ($urandom % 6 == 0) ? 1 : 0;
        d = ($urandom % 5 == 0) ? rnd_len() : n;
        send(n, d, h, ($urandom % 3 == 0), ($urandom % 4 == 0), 0, "");
        check_all("R7 R8 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule